// File: doc/BRIEF.md
# FIFO Threshold Interrupt and Status Unit

This block sits beside the transmit and receive FIFOs of a serial peripheral controller. It watches both fill levels and turns them into status flags, four raw interrupt sources, a masked status word and one interrupt line. It holds the threshold, mask and idle-limit settings. The two error sources, receive overflow and receive idle timeout, are sticky. Software clears them by writing ones. The two level sources follow the FIFO fill levels and are never stored.

The FIFO storage and the serial shifter are outside this block. The unit only sees the level counts, the receive push and pop strobes, the shifter busy signal and a small register port. Register writes take effect at the next clock edge. Register reads are combinational from the current address.

Register addresses are: 0 FIFO control, 1 mask, 2 idle limit, 3 status, 4 raw interrupts, 5 masked interrupts, 6 clear (write only). Addresses 6 and 7 read as zero.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Status (address 3) has five bits: bit 0 is set when the transmit level is 0; bit 1 is set when the transmit level is below 256; bit 2 is set when the receive level is not 0; bit 3 is set when the receive level equals 256; bit 4 copies `shift_busy`.
- R2: The FIFO control word (address 0) holds the transmit threshold code in bits 5:3 and the receive threshold code in bits 11:9. Codes 0 through 6 select 1, 4, 8, 16, 32, 64 and 128. Code 7 selects 128. Both codes reset to 0.
- R3: Raw bit 3 (transmit level) is 1 exactly while the transmit level is at most the selected transmit threshold.
- R4: Raw bit 2 (receive level) is 1 exactly while the receive level is at least the selected receive threshold.
- R5: Raw bit 0 (overflow) is set at the clock edge where `rx_push` is high and the receive level is 256. It then stays set until it is cleared.
- R6: Raw bit 1 (timeout) is set at the edge that ends the Nth consecutive qualifying cycle. A cycle qualifies when the receive level is nonzero, the level is below the receive threshold, and there is no push and no pop. N is the idle limit at address 2, which resets to 64. A limit of 0 disables the timeout. The bit fires once per idle run and stays set until it is cleared.
- R7: Writing address 6 with bit 0 or bit 1 set clears overflow or timeout at that edge. A set condition at the same edge wins over the clear. Bits 2 and 3 of the clear word have no effect.
- R8: The mask (address 1, bits 3:0) resets to 4'hF. A 1 in the mask suppresses the matching source. Masked status (address 5) equals raw AND NOT mask.
- R9: `irq` is 1 exactly when any masked status bit is 1.
- R10: Raw status reads at address 4 with the bit positions given in R3 to R6. After reset both sticky bits are 0. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | 9 | Transmit FIFO entry count, 0 to 256 |
| rx_level | input | 9 | Receive FIFO entry count, 0 to 256 |
| rx_push | input | 1 | A received word is offered to the receive FIFO |
| rx_pop | input | 1 | A word is read from the receive FIFO |
| shift_busy | input | 1 | Serial shifter is active |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check several rules on every cycle:
- overflow sets after a push into a full receive FIFO;
- the sticky bits hold until they are cleared, and a clear without a competing set removes them;
- an empty transmit FIFO or a full receive FIFO always raises its level source;
- an all-ones mask keeps `irq` low.

Other behaviour only the bench scenarios can show:
- the exact cycle at which the idle count fires;
- that the timeout fires only once per idle run and never when the limit is 0;
- every threshold code at its boundary levels;
- that a clear loses against a simultaneous overflow.

// File: rtl/fiq_pkg.sv
package fiq_pkg;

  typedef enum logic [2:0] {
    ADR_FCTL  = 3'd0,
    ADR_MASK  = 3'd1,
    ADR_IDLE  = 3'd2,
    ADR_STAT  = 3'd3,
    ADR_RAW   = 3'd4,
    ADR_MSKD  = 3'd5,
    ADR_CLR   = 3'd6,
    ADR_SPARE = 3'd7
  } reg_sel_e;

  localparam int SRC_OVF  = 0;
  localparam int SRC_IDLE = 1;
  localparam int SRC_RXLV = 2;
  localparam int SRC_TXLV = 3;
  localparam int NSRC     = 4;
  localparam int NSTAT    = 5;
  localparam int NSTICKY  = 2;

  // Threshold code to entry count: 0 -> 1, k -> 2^(k+1), codes above 6 saturate.
  function automatic logic [7:0] thr_of(input logic [2:0] code);
    logic [7:0] v;
    if (code == 3'd0)       v = 8'd1;
    else if (code >= 3'd6)  v = 8'd128;
    else                    v = 8'd1 << (code + 3'd1);
    return v;
  endfunction

endpackage

// File: rtl/fiq_cfg_regs.sv
module fiq_cfg_regs #(
  parameter int DW     = 16,
  parameter int TO_RST = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [2:0]    tx_code,
  output logic [2:0]    rx_code,
  output logic [3:0]    mask,
  output logic [DW-1:0] idle_lim
);
  import fiq_pkg::*;

  logic [2:0]    tx_code_d, rx_code_d;
  logic [3:0]    mask_d;
  logic [DW-1:0] idle_lim_d;

  always_comb begin
    tx_code_d  = tx_code;
    rx_code_d  = rx_code;
    mask_d     = mask;
    idle_lim_d = idle_lim;
    if (wr) begin
      case (addr)
        ADR_FCTL: begin
          tx_code_d = wdata[5:3];
          rx_code_d = wdata[11:9];
        end
        ADR_MASK: mask_d     = wdata[3:0];
        ADR_IDLE: idle_lim_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_code  <= 3'd0;
      rx_code  <= 3'd0;
      mask     <= 4'hF;
      idle_lim <= DW'(TO_RST);
    end else if (wr) begin
      tx_code  <= tx_code_d;
      rx_code  <= rx_code_d;
      mask     <= mask_d;
      idle_lim <= idle_lim_d;
    end
  end

endmodule

// File: rtl/fiq_rx_idle.sv
module fiq_rx_idle #(
  parameter int LVL_W = 9,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_thr,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic [CW-1:0]    limit,
  output logic             fire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          qual, cnt_en;

  assign qual = (rx_level != '0) && (rx_level < rx_thr) && !rx_push && !rx_pop;

  always_comb begin
    if (!qual)               cnt_d = '0;
    else if (cnt_q != limit) cnt_d = cnt_q + CW'(1);
    else                     cnt_d = cnt_q;
  end

  assign cnt_en = (cnt_d != cnt_q);
  assign fire   = qual && (limit != '0) && (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fiq_sticky.sv
module fiq_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic d, en;
    assign d  = set[g] | (q[g] & ~clr[g]);
    assign en = (d != q[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[g] <= 1'b0;
      else if (en) q[g] <= d;
    end
  end

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit #(
  parameter int DEPTH  = 256,
  parameter int DW     = 16,
  parameter int TO_RST = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             shift_busy,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq
);
  import fiq_pkg::*;

  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic [2:0]         tx_code, rx_code;
  logic [3:0]         irq_mask;
  logic [DW-1:0]      idle_lim;
  logic [LVL_W-1:0]   tx_thr, rx_thr;
  logic               idle_fire;
  logic [NSTICKY-1:0] stk_set, stk_clr, stk_q;
  logic [NSRC-1:0]    raw_st, msk_st;
  logic [NSTAT-1:0]   stat;

  fiq_cfg_regs #(.DW(DW), .TO_RST(TO_RST)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .tx_code  (tx_code),
    .rx_code  (rx_code),
    .mask     (irq_mask),
    .idle_lim (idle_lim)
  );

  assign tx_thr = LVL_W'(thr_of(tx_code));
  assign rx_thr = LVL_W'(thr_of(rx_code));

  fiq_rx_idle #(.LVL_W(LVL_W), .CW(DW)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_level (rx_level),
    .rx_thr   (rx_thr),
    .rx_push  (rx_push),
    .rx_pop   (rx_pop),
    .limit    (idle_lim),
    .fire     (idle_fire)
  );

  assign stk_set[SRC_OVF]  = rx_push && (rx_level == FULL);
  assign stk_set[SRC_IDLE] = idle_fire;
  assign stk_clr = (reg_wr && reg_addr == ADR_CLR) ? reg_wdata[NSTICKY-1:0] : '0;

  fiq_sticky #(.N(NSTICKY)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (stk_set),
    .clr   (stk_clr),
    .q     (stk_q)
  );

  assign raw_st[SRC_OVF]  = stk_q[SRC_OVF];
  assign raw_st[SRC_IDLE] = stk_q[SRC_IDLE];
  assign raw_st[SRC_RXLV] = (rx_level >= rx_thr);
  assign raw_st[SRC_TXLV] = (tx_level <= tx_thr);
  assign msk_st = raw_st & ~irq_mask;
  assign irq    = |msk_st;

  assign stat[0] = (tx_level == '0);
  assign stat[1] = (tx_level < FULL);
  assign stat[2] = (rx_level != '0);
  assign stat[3] = (rx_level == FULL);
  assign stat[4] = shift_busy;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_FCTL: begin
        reg_rdata[5:3]  = tx_code;
        reg_rdata[11:9] = rx_code;
      end
      ADR_MASK: reg_rdata[3:0]       = irq_mask;
      ADR_IDLE: reg_rdata            = idle_lim;
      ADR_STAT: reg_rdata[NSTAT-1:0] = stat;
      ADR_RAW:  reg_rdata[NSRC-1:0]  = raw_st;
      ADR_MSKD: reg_rdata[NSRC-1:0]  = msk_st;
      default:  reg_rdata            = '0;
    endcase
  end

endmodule

// File: rtl/fiq_checker.sv
module fiq_checker #(
  parameter int DEPTH = 256,
  parameter int LVL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_push,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_level,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [1:0]       clr_bits,
  input logic [3:0]       raw,
  input logic [3:0]       mask,
  input logic             irq
);
  logic ovf_hit, clr_ovf, clr_idle;
  assign ovf_hit  = rx_push && (rx_level == LVL_W'(DEPTH));
  assign clr_ovf  = reg_wr && (reg_addr == 3'd6) && clr_bits[0];
  assign clr_idle = reg_wr && (reg_addr == 3'd6) && clr_bits[1];

  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> raw[0]);
  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    raw[0] && !clr_ovf |=> raw[0]);
  p_ovf_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ovf && !ovf_hit |=> !raw[0]);
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    raw[1] && !clr_idle |=> raw[1]);
  p_idle_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw[1]) |-> $past(rx_level) != '0);
  p_tx_empty_lvl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level == '0 |-> raw[3]);
  p_rx_full_lvl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level == LVL_W'(DEPTH) |-> raw[2]);
  p_mask_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask == 4'hF |-> !irq);
  p_ovf_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    raw[0] && !mask[0] |-> irq);

endmodule

bind spi_fifo_irq_unit fiq_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fiq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_push  (rx_push),
  .rx_level (rx_level),
  .tx_level (tx_level),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .clr_bits (reg_wdata[1:0]),
  .raw      (raw_st),
  .mask     (irq_mask),
  .irq      (irq)
);

// File: tb/spi_fifo_irq_unit_bench.sv
module spi_fifo_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  tx_level, rx_level;
  logic        rx_push, rx_pop, shift_busy, reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state, derived from the requirements
  int       m_txc, m_rxc, m_lim, m_cnt;
  bit [3:0] m_mask;
  bit       m_ovf, m_to;

  always #10 clk = ~clk;

  spi_fifo_irq_unit u_spi_fifo_irq_unit (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .rx_push(rx_push), .rx_pop(rx_pop), .shift_busy(shift_busy),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic int thr(input int code);
    if (code == 0) return 1;
    if (code >= 6) return 128;
    return 1 << (code + 1);
  endfunction

  function automatic bit [3:0] exp_raw();
    return {bit'(tx_level <= thr(m_txc)), bit'(rx_level >= thr(m_rxc)), m_to, m_ovf};
  endfunction

  function automatic bit [4:0] exp_stat();
    return {shift_busy, bit'(rx_level == 256), bit'(rx_level != 0),
            bit'(tx_level < 256), bit'(tx_level == 0)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input int adr, input string req, input int exp);
    reg_addr = 3'(adr);
    #1;
    chk(req, int'(reg_rdata), exp);
  endtask

  // one clock edge, model advanced with the same inputs
  task automatic tick();
    bit qual, fire, sovf;
    bit [1:0] clr;
    int ncnt;
    qual = (rx_level != 0) && (rx_level < thr(m_rxc)) && !rx_push && !rx_pop;
    fire = qual && (m_lim != 0) && (m_cnt == m_lim - 1);
    if (!qual) ncnt = 0;
    else if (m_cnt != m_lim) ncnt = (m_cnt + 1) & 16'hFFFF;
    else ncnt = m_cnt;
    sovf = rx_push && (rx_level == 256);
    clr = (reg_wr && reg_addr == 3'd6) ? reg_wdata[1:0] : 2'b00;
    @(posedge clk);
    #1;
    m_ovf = sovf | (m_ovf & !clr[0]);
    m_to  = fire | (m_to & !clr[1]);
    m_cnt = ncnt;
    if (reg_wr) begin
      case (reg_addr)
        3'd0: begin m_txc = int'(reg_wdata[5:3]); m_rxc = int'(reg_wdata[11:9]); end
        3'd1: m_mask = reg_wdata[3:0];
        3'd2: m_lim = int'(reg_wdata);
        default: ;
      endcase
    end
    rx_push = 1'b0;
    rx_pop  = 1'b0;
    reg_wr  = 1'b0;
  endtask

  task automatic wr(input int adr, input int data);
    reg_wr = 1'b1;
    reg_addr = 3'(adr);
    reg_wdata = 16'(data);
    tick();
  endtask

  task automatic full_check(input string tag);
    bit [3:0] r;
    r = exp_raw();
    rd(4, {tag, " R10 raw"}, int'(r));
    rd(5, {tag, " R8 masked"}, int'(r & ~m_mask));
    rd(3, {tag, " R1 status"}, int'(exp_stat()));
    chk({tag, " R9 irq"}, int'(irq), int'(|(r & ~m_mask)));
  endtask

  function automatic logic [8:0] pick_lvl();
    int s;
    s = int'($urandom % 4);
    if (s == 0) return 9'd256;
    if (s == 1) return 9'd0;
    return 9'($urandom % 257);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; tx_level = 0; rx_level = 0; rx_push = 0; rx_pop = 0;
    shift_busy = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    m_txc = 0; m_rxc = 0; m_lim = 64; m_cnt = 0; m_mask = 4'hF; m_ovf = 0; m_to = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    rd(3, "R1 reset status", 5'b00011);
    rd(4, "R10 reset raw", 4'b1000);
    rd(5, "R8 reset masked", 0);
    chk("R8 reset irq", int'(irq), 0);
    rd(0, "R2 reset ctrl", 0);
    rd(1, "R8 reset mask", 15);
    rd(2, "R6 reset limit", 64);
    rd(7, "R10 spare reads zero", 0);

    wr(1, 0);
    chk("R9 irq from tx level", int'(irq), 1);

    // threshold codes at their boundaries
    for (int c = 0; c < 8; c++) begin
      int t;
      wr(0, (c << 3) | (c << 9));
      rd(0, "R2 ctrl readback", (c << 3) | (c << 9));
      t = thr(c);
      rx_level = 9'(t);     rd(4, "R4 rx at threshold", {1'b0, 1'b1, m_to, m_ovf} | 4'b0000 | (int'(tx_level <= t) << 3));
      rx_level = 9'(t - 1); rd(4, "R4 rx below threshold", int'(exp_raw()));
      chk("R4 rx below bit", int'(reg_rdata[2]), 0);
      tx_level = 9'(t);     #1; chk("R3 tx at threshold", int'(reg_rdata[3]), 1);
      tx_level = 9'(t + 1); #1; chk("R3 tx above threshold", int'(reg_rdata[3]), 0);
      rx_level = 0; tx_level = 0;
    end

    // status flags
    tx_level = 256; rx_level = 256; shift_busy = 1;
    rd(3, "R1 full/busy status", 5'b11100);
    shift_busy = 0; tx_level = 0; rx_level = 0;

    // overflow
    wr(0, 0);
    rx_level = 256; rx_push = 1; tick();
    rd(4, "R5 overflow set", int'(exp_raw()));
    chk("R5 overflow bit", int'(reg_rdata[0]), 1);
    tick(); tick();
    rd(4, "R5 overflow sticky", int'(exp_raw()));
    chk("R5 overflow held", int'(reg_rdata[0]), 1);
    wr(6, 4'b1100);
    rd(4, "R7 level bits unaffected by clear", 4'b1101);
    reg_wdata = 16'h0001; reg_wr = 1; reg_addr = 6; rx_push = 1; tick();
    rd(4, "R7 set wins over clear", int'(exp_raw()));
    chk("R7 set wins bit", int'(reg_rdata[0]), 1);
    rx_level = 0;
    wr(6, 1);
    rd(4, "R7 overflow cleared", int'(exp_raw()));
    chk("R7 cleared bit", int'(reg_rdata[0]), 0);

    // idle timeout, limit 4, rx threshold 16
    wr(0, 3 << 9);
    wr(2, 4);
    rx_level = 5; rx_push = 1; tick();
    tick(); tick(); tick();
    rd(4, "R6 no timeout after 3 idle", int'(exp_raw()));
    chk("R6 idle bit after 3", int'(reg_rdata[1]), 0);
    tick();
    rd(4, "R6 timeout after 4 idle", int'(exp_raw()));
    chk("R6 idle bit after 4", int'(reg_rdata[1]), 1);
    wr(6, 2);
    tick(); tick(); tick(); tick(); tick();
    rd(4, "R6 fires once per idle run", int'(exp_raw()));
    chk("R6 no refire", int'(reg_rdata[1]), 0);
    rx_pop = 1; tick();
    repeat (4) tick();
    rd(4, "R6 new run fires", int'(exp_raw()));
    chk("R6 refire after pop", int'(reg_rdata[1]), 1);
    wr(2, 0);
    wr(6, 2);
    rx_pop = 1; tick();
    repeat (10) tick();
    rd(4, "R6 limit zero disables", int'(exp_raw()));
    chk("R6 disabled bit", int'(reg_rdata[1]), 0);

    // mask selectivity
    wr(1, 4'b0111);
    rx_level = 0; tx_level = 0;
    rd(5, "R8 only tx level visible", int'(exp_raw() & ~m_mask));
    wr(1, 4'b1000);
    rd(5, "R8 tx level masked", int'(exp_raw() & 4'b0111));
    chk("R9 irq masked off", int'(irq), int'(|(exp_raw() & 4'b0111)));

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int op;
      if ($urandom % 8 == 0) rx_level = pick_lvl();
      if ($urandom % 8 == 0) tx_level = pick_lvl();
      rx_push = ($urandom % 5 == 0);
      rx_pop  = ($urandom % 6 == 0);
      shift_busy = ($urandom % 2 == 0);
      op = int'($urandom % 16);
      case (op)
        0: wr(0, int'((($urandom % 8) << 3) | (($urandom % 8) << 9)));
        1: wr(1, int'($urandom % 16));
        2: wr(6, int'($urandom % 4));
        3: wr(2, int'(1 + $urandom % 6));
        default: tick();
      endcase
      full_check("rand");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule